// File: doc/BRIEF.md
# Linked Memory Command Encoder

This block sits between a load/store pipeline and the memory port. Each cycle it can accept one request: a direction (read or write) and three attribute flags (locked, swap, compare-and-swap). It turns that request into the exact command placed on the memory port. A compare-and-swap write also carries a compare operand, which the block attaches to the outgoing command. Every output is registered, so the command and the completion report appear one clock after the request is accepted.

For store-conditional support the block keeps one link reservation per hardware thread. A reservation is a valid bit plus a cache-line address. It is set when a load-locked response comes back for that thread. It is cleared by any store-conditional from that thread, or by an external invalidate that names the same line. A store-conditional that finds no matching reservation is not sent to memory. It is still reported complete, with a failure result, in the same cycle a successful one would be.

Top module: `llsc_cmd_encoder`

## Requirements
- R1: A read with the locked flag produces command code 1 (load-locked). Any other read produces code 0 (plain read), whatever its swap or compare-and-swap flags say.
- R2: A write with the swap flag produces code 4 (swap), whether or not the locked flag is also set.
- R3: A write with the locked flag and without swap produces code 3 (store-conditional). A write with neither flag produces code 2 (plain write).
- R4: A write with the compare-and-swap flag raises `mem_cmp_en` and places `req_cmp` on `mem_cmp`. On a read, `mem_cmp_en` stays low.
- R5: Each accepted request gives exactly one `fin_valid` pulse on the following clock edge. When no request is accepted, `fin_valid` and `mem_valid` stay low.
- R6: A load-locked response records a reservation for its thread, holding the line address it carries. This replaces any earlier reservation of that thread.
- R7: A store-conditional succeeds only if its thread holds a valid reservation whose line equals the request's line (address bits above `LINE_OFF`). On success it issues code 3 with `fin_sc_ok` high.
- R8: A failing store-conditional makes no memory access. `mem_valid` is low, and `fin_valid` and `fin_suppress` are high with `fin_sc_ok` low.
- R9: Any store-conditional, whether it passes or fails, clears its own thread's reservation. A second store-conditional to the same line therefore fails.
- R10: An invalidate clears, at the next edge, the reservation of every thread holding that line. Reservations on other lines are kept.
- R11: An invalidate takes effect in its own cycle in two cases. A store-conditional checked in that cycle against the invalidated line fails. A load-locked response for that line arriving in that cycle records no reservation.
- R12: Reservations are private to each thread. A store-conditional from one thread neither uses nor clears another thread's reservation.
- R13: Synchronous reset clears all reservations and drives all valid outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_locked | input | 1 | Locked attribute |
| req_swap | input | 1 | Swap attribute |
| req_cswap | input | 1 | Compare-and-swap attribute |
| req_tid | input | TID_W | Requesting thread |
| req_addr | input | ADDR_W | Request byte address |
| req_cmp | input | DATA_W | Compare operand for compare-and-swap |
| ll_rsp_valid | input | 1 | Load-locked response returned |
| ll_rsp_tid | input | TID_W | Thread of that response |
| ll_rsp_line | input | ADDR_W-LINE_OFF | Line address of that response |
| inv_valid | input | 1 | External line invalidate |
| inv_line | input | ADDR_W-LINE_OFF | Line being invalidated |
| mem_valid | output | 1 | Memory command issued |
| mem_cmd | output | 3 | Command code (0 read, 1 load-locked, 2 write, 3 store-conditional, 4 swap) |
| mem_addr | output | ADDR_W | Command address |
| mem_tid | output | TID_W | Command thread |
| mem_cmp | output | DATA_W | Attached compare operand |
| mem_cmp_en | output | 1 | Compare operand attached |
| fin_valid | output | 1 | Request completed |
| fin_tid | output | TID_W | Completed thread |
| fin_suppress | output | 1 | Completed without memory access |
| fin_sc_ok | output | 1 | Store-conditional succeeded |

## Verification
Two kinds of event can land in the same cycle as an invalidate for the same line. One is a store-conditional check. The other is a load-locked response. The bench provokes the first by driving a store-conditional and an invalidate of its reserved line on the same edge. It provokes the second by raising a load-locked response and an invalidate of that line together. In both cases the outcome is judged only at the ports: the colliding store-conditional must report a suppressed failure. For the response case, a later store-conditional to that line must also fail, which shows the reservation was never recorded.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    MC_READ   = 3'd0,
    MC_LDLOCK = 3'd1,
    MC_WRITE  = 3'd2,
    MC_STCOND = 3'd3,
    MC_SWAP   = 3'd4
  } mem_cmd_e;
endpackage

// File: rtl/llsc_cmd_map.sv
module llsc_cmd_map
  import llsc_pkg::*;
(
  input  logic     is_write,
  input  logic     locked,
  input  logic     swap,
  input  logic     cswap,
  output mem_cmd_e cmd,
  output logic     is_sc,
  output logic     cmp_en
);
  always_comb begin
    is_sc  = 1'b0;
    cmp_en = 1'b0;
    if (!is_write) begin
      cmd = locked ? MC_LDLOCK : MC_READ;
    end else begin
      cmp_en = cswap;
      if (swap) begin
        cmd = MC_SWAP;
      end else if (locked) begin
        cmd   = MC_STCOND;
        is_sc = 1'b1;
      end else begin
        cmd = MC_WRITE;
      end
    end
  end
endmodule

// File: rtl/llsc_link_table.sv
module llsc_link_table #(
  parameter int THREADS = 4,
  parameter int TID_W   = 2,
  parameter int LINE_AW = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [TID_W-1:0]   set_tid,
  input  logic [LINE_AW-1:0] set_line,
  input  logic               inv_en,
  input  logic [LINE_AW-1:0] inv_line,
  input  logic               chk_en,
  input  logic [TID_W-1:0]   chk_tid,
  input  logic [LINE_AW-1:0] chk_line,
  output logic               chk_hit
);
  logic [THREADS-1:0] hit_vec;
  logic               set_blocked;

  // a response for a line being invalidated in the same cycle is dropped
  assign set_blocked = inv_en && (inv_line == set_line);

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic               vld_q;
    logic [LINE_AW-1:0] line_q;
    logic               inv_here;
    logic               set_here;
    logic               chk_here;

    assign inv_here = inv_en && (inv_line == line_q);
    assign set_here = set_en && (set_tid == TID_W'(t));
    assign chk_here = chk_en && (chk_tid == TID_W'(t));
    assign hit_vec[t] = vld_q && (line_q == chk_line) && !inv_here;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q  <= 1'b0;
        line_q <= '0;
      end else if (set_here) begin
        vld_q  <= !set_blocked;
        line_q <= set_line;
      end else if (chk_here || inv_here) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign chk_hit = hit_vec[chk_tid];
endmodule

// File: rtl/llsc_cmd_encoder.sv
module llsc_cmd_encoder
  import llsc_pkg::*;
#(
  parameter int THREADS  = 4,
  parameter int TID_W    = 2,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int LINE_OFF = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       req_locked,
  input  logic                       req_swap,
  input  logic                       req_cswap,
  input  logic [TID_W-1:0]           req_tid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_cmp,
  input  logic                       ll_rsp_valid,
  input  logic [TID_W-1:0]           ll_rsp_tid,
  input  logic [ADDR_W-LINE_OFF-1:0] ll_rsp_line,
  input  logic                       inv_valid,
  input  logic [ADDR_W-LINE_OFF-1:0] inv_line,
  output logic                       mem_valid,
  output logic [2:0]                 mem_cmd,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [TID_W-1:0]           mem_tid,
  output logic [DATA_W-1:0]          mem_cmp,
  output logic                       mem_cmp_en,
  output logic                       fin_valid,
  output logic [TID_W-1:0]           fin_tid,
  output logic                       fin_suppress,
  output logic                       fin_sc_ok
);
  localparam int LINE_AW = ADDR_W - LINE_OFF;

  mem_cmd_e           nxt_cmd;
  logic               nxt_is_sc;
  logic               nxt_cmp_en;
  logic               link_hit;
  logic               drop_sc;
  logic [LINE_AW-1:0] req_line;

  assign req_line = req_addr[ADDR_W-1:LINE_OFF];

  llsc_cmd_map u_map (
    .is_write (req_write),
    .locked   (req_locked),
    .swap     (req_swap),
    .cswap    (req_cswap),
    .cmd      (nxt_cmd),
    .is_sc    (nxt_is_sc),
    .cmp_en   (nxt_cmp_en)
  );

  llsc_link_table #(
    .THREADS (THREADS),
    .TID_W   (TID_W),
    .LINE_AW (LINE_AW)
  ) u_links (
    .clk      (clk),
    .rst      (rst),
    .set_en   (ll_rsp_valid),
    .set_tid  (ll_rsp_tid),
    .set_line (ll_rsp_line),
    .inv_en   (inv_valid),
    .inv_line (inv_line),
    .chk_en   (req_valid && nxt_is_sc),
    .chk_tid  (req_tid),
    .chk_line (req_line),
    .chk_hit  (link_hit)
  );

  assign drop_sc = nxt_is_sc && !link_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid    <= 1'b0;
      mem_cmd      <= MC_READ;
      mem_addr     <= '0;
      mem_tid      <= '0;
      mem_cmp      <= '0;
      mem_cmp_en   <= 1'b0;
      fin_valid    <= 1'b0;
      fin_tid      <= '0;
      fin_suppress <= 1'b0;
      fin_sc_ok    <= 1'b0;
    end else begin
      mem_valid    <= req_valid && !drop_sc;
      fin_valid    <= req_valid;
      fin_suppress <= req_valid && drop_sc;
      fin_sc_ok    <= req_valid && nxt_is_sc && link_hit;
      if (req_valid) begin
        mem_cmd    <= nxt_cmd;
        mem_addr   <= req_addr;
        mem_tid    <= req_tid;
        mem_cmp    <= nxt_cmp_en ? req_cmp : '0;
        mem_cmp_en <= nxt_cmp_en;
        fin_tid    <= req_tid;
      end
    end
  end
endmodule

// File: rtl/llsc_cmd_encoder_chk.sv
module llsc_cmd_encoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_write,
  input logic       req_locked,
  input logic       req_swap,
  input logic       mem_valid,
  input logic [2:0] mem_cmd,
  input logic       mem_cmp_en,
  input logic       fin_valid,
  input logic       fin_suppress,
  input logic       fin_sc_ok
);
  a_r8_suppress_no_access: assert property (@(posedge clk) disable iff (rst)
    fin_suppress |-> (!mem_valid && fin_valid && !fin_sc_ok));

  a_r5_done_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> fin_valid);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!fin_valid && !mem_valid));

  a_r1_load_locked: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_locked) |=> (mem_valid && mem_cmd == 3'd1));

  a_r2_swap_cmd: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_swap) |=> (mem_valid && mem_cmd == 3'd4));

  a_r7_sc_ok_issues: assert property (@(posedge clk) disable iff (rst)
    fin_sc_ok |-> (mem_valid && mem_cmd == 3'd3));

  a_r4_no_cmp_on_read: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> !mem_cmp_en);
endmodule

bind llsc_cmd_encoder llsc_cmd_encoder_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_locked   (req_locked),
  .req_swap     (req_swap),
  .mem_valid    (mem_valid),
  .mem_cmd      (mem_cmd),
  .mem_cmp_en   (mem_cmp_en),
  .fin_valid    (fin_valid),
  .fin_suppress (fin_suppress),
  .fin_sc_ok    (fin_sc_ok)
);

// File: tb/llsc_cmd_encoder_test.sv
`timescale 1ns/1ps
module llsc_cmd_encoder_test;
  localparam int TID_W = 2;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int LOFF = 6;
  localparam int LAW = ADDR_W - LOFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_locked = 0, req_swap = 0, req_cswap = 0;
  logic [TID_W-1:0] req_tid = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_cmp = '0;
  logic ll_rsp_valid = 0;
  logic [TID_W-1:0] ll_rsp_tid = '0;
  logic [LAW-1:0] ll_rsp_line = '0;
  logic inv_valid = 0;
  logic [LAW-1:0] inv_line = '0;
  logic mem_valid, mem_cmp_en, fin_valid, fin_suppress, fin_sc_ok;
  logic [2:0] mem_cmd;
  logic [ADDR_W-1:0] mem_addr;
  logic [TID_W-1:0] mem_tid, fin_tid;
  logic [DATA_W-1:0] mem_cmp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [31:0] A  = 32'h0000_1000;
  localparam logic [31:0] A2 = 32'h0000_1004;
  localparam logic [31:0] B  = 32'h0000_2040;

  always #2.5 clk = ~clk;

  llsc_cmd_encoder uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_locked(req_locked),
    .req_swap(req_swap), .req_cswap(req_cswap), .req_tid(req_tid),
    .req_addr(req_addr), .req_cmp(req_cmp),
    .ll_rsp_valid(ll_rsp_valid), .ll_rsp_tid(ll_rsp_tid), .ll_rsp_line(ll_rsp_line),
    .inv_valid(inv_valid), .inv_line(inv_line),
    .mem_valid(mem_valid), .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_tid(mem_tid),
    .mem_cmp(mem_cmp), .mem_cmp_en(mem_cmp_en),
    .fin_valid(fin_valid), .fin_tid(fin_tid), .fin_suppress(fin_suppress),
    .fin_sc_ok(fin_sc_ok)
  );

  function automatic logic [LAW-1:0] line_of(input logic [31:0] a);
    return a[ADDR_W-1:LOFF];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // set request fields; caller ticks
  task automatic put_req(input logic w, l, s, c, input logic [TID_W-1:0] tid,
                         input logic [31:0] addr, input logic [63:0] cv);
    req_valid = 1; req_write = w; req_locked = l; req_swap = s; req_cswap = c;
    req_tid = tid; req_addr = addr; req_cmp = cv;
  endtask

  task automatic clear_in();
    req_valid = 0; req_write = 0; req_locked = 0; req_swap = 0; req_cswap = 0;
    ll_rsp_valid = 0; inv_valid = 0;
  endtask

  task automatic send(input logic w, l, s, c, input logic [TID_W-1:0] tid,
                      input logic [31:0] addr, input logic [63:0] cv);
    put_req(w, l, s, c, tid, addr, cv);
    tick();
    clear_in();
  endtask

  task automatic ll(input logic [TID_W-1:0] tid, input logic [31:0] addr);
    ll_rsp_valid = 1; ll_rsp_tid = tid; ll_rsp_line = line_of(addr);
    tick();
    clear_in();
  endtask

  task automatic expect_issue(input string tag, input logic [2:0] cmd);
    chk({tag, " mem_valid"}, mem_valid, 1);
    chk({tag, " mem_cmd"}, mem_cmd, cmd);
    chk({tag, " fin_valid"}, fin_valid, 1);
    chk({tag, " fin_suppress"}, fin_suppress, 0);
  endtask

  task automatic expect_sc(input string tag, input bit ok);
    chk({tag, " fin_valid"}, fin_valid, 1);
    chk({tag, " fin_sc_ok"}, fin_sc_ok, ok);
    chk({tag, " mem_valid"}, mem_valid, ok);
    chk({tag, " fin_suppress"}, fin_suppress, !ok);
    if (ok) chk({tag, " mem_cmd"}, mem_cmd, 3'd3);
  endtask

  task automatic t_reset();
    chk("R13 reset mem_valid", mem_valid, 0);
    chk("R13 reset fin_valid", fin_valid, 0);
    ll(0, A);
    rst = 1; tick(); rst = 0;
    chk("R13 post-reset fin_valid", fin_valid, 0);
    send(1, 1, 0, 0, 0, A, 0);
    expect_sc("R13 link cleared by reset", 0);
  endtask

  task automatic t_reads();
    send(0, 0, 0, 0, 1, A, 0);
    expect_issue("R1 plain read", 3'd0);
    chk("R5 addr", mem_addr, A);
    chk("R5 tid", mem_tid, 1);
    send(0, 1, 0, 0, 2, B, 0);
    expect_issue("R1 locked read", 3'd1);
    send(0, 0, 1, 1, 0, A, 64'h55);
    expect_issue("R1 swap flags on read ignored", 3'd0);
    chk("R4 no cmp on read", mem_cmp_en, 0);
    tick();
    chk("R5 idle no fin", fin_valid, 0);
    chk("R5 idle no mem", mem_valid, 0);
  endtask

  task automatic t_writes();
    send(1, 0, 0, 0, 3, B, 0);
    expect_issue("R3 plain write", 3'd2);
    send(1, 0, 1, 0, 0, A, 0);
    expect_issue("R2 swap", 3'd4);
    send(1, 1, 1, 0, 0, A, 0);
    expect_issue("R2 swap over locked", 3'd4);
    chk("R2 no sc result", fin_sc_ok, 0);
    send(1, 0, 0, 1, 1, B, 64'hDEAD_BEEF_0123_4567);
    expect_issue("R4 cswap", 3'd2);
    chk("R4 cmp_en", mem_cmp_en, 1);
    chk("R4 cmp value", mem_cmp, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_sc_basic();
    ll(1, A);
    send(1, 1, 0, 0, 1, A2, 0);
    expect_sc("R7 sc same line ok", 1);
    send(1, 1, 0, 0, 1, A2, 0);
    expect_sc("R9 second sc fails", 0);
    ll(2, A);
    send(1, 1, 0, 0, 2, B, 0);
    expect_sc("R8 sc other line fails", 0);
    send(1, 1, 0, 0, 2, A, 0);
    expect_sc("R9 failed sc also cleared", 0);
    ll(3, A);
    ll(3, B);
    send(1, 1, 0, 0, 3, B, 0);
    expect_sc("R6 newer link replaces older", 1);
  endtask

  task automatic t_threads();
    ll(0, A);
    send(1, 1, 0, 0, 3, A, 0);
    expect_sc("R12 other thread has no link", 0);
    send(1, 1, 0, 0, 0, A, 0);
    expect_sc("R12 owner link kept", 1);
  endtask

  task automatic t_inv();
    ll(0, A);
    ll(1, A2);
    ll(2, B);
    inv_valid = 1; inv_line = line_of(A);
    tick(); clear_in();
    send(1, 1, 0, 0, 0, A, 0);
    expect_sc("R10 thread0 cleared", 0);
    send(1, 1, 0, 0, 1, A, 0);
    expect_sc("R10 thread1 cleared", 0);
    send(1, 1, 0, 0, 2, B, 0);
    expect_sc("R10 other line kept", 1);
  endtask

  task automatic t_collide();
    ll(0, A);
    put_req(1, 1, 0, 0, 0, A, 0);
    inv_valid = 1; inv_line = line_of(A);
    tick(); clear_in();
    expect_sc("R11 sc with same-cycle invalidate", 0);
    ll_rsp_valid = 1; ll_rsp_tid = 1; ll_rsp_line = line_of(B);
    inv_valid = 1; inv_line = line_of(B);
    tick(); clear_in();
    send(1, 1, 0, 0, 1, B, 0);
    expect_sc("R11 link dropped by same-cycle invalidate", 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    t_reset();
    t_reads();
    t_writes();
    t_sc_basic();
    t_threads();
    t_inv();
    t_collide();
    tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule